// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block runs external memory accesses for an 8-bit controller with a 16-bit address space. The low address byte and the data byte share one bidirectional bus, written here as a separate output, output enable and input. The upper address byte has its own pins. The block also drives an address latch strobe, active-low read and write strobes, and a clock output at one eighth of the block clock. The block clock runs at twice the oscillator rate, so one tick is half an oscillator period and one clock-out period is one basic bus cycle of four oscillator periods.

An internal master issues requests on a valid/ready channel. The channel carries the address, a write flag and write data. A request is taken on a rising clock edge where both `req_valid` and `req_ready` are high. `req_ready` depends only on the block's own state and never on the request, so a master may hold `req_valid` high for as long as it likes. The response has no back-pressure. `rsp_done` pulses high for one tick per access, with `rsp_ext` and `rsp_rdata`, and the master must take it in that tick. A built-in decoder sends the on-chip ROM window and the on-chip I/O window to an internal response. Those addresses never touch the pins.

A slow device can stretch a strobe by holding `wait_n` low. The block samples `wait_n` once per clock-out period.

Top module: `xmem_mux_bus`

## Requirements
- R1: While `rst_n` is low: `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `ahi_oe`=0 and `rsp_done`=0.
- R2: `clk_out` has a period of 8 ticks. It is high for the first 4 ticks after reset ends and low for the next 4. `req_ready` is high only when the block is idle and in the last tick of a `clk_out` period, so `clk_out` is low whenever `req_ready` is high.
- R3: An external access occupies phases 0 to 7, one tick each, and phase 0 is the tick after acceptance. `ale` is high in phases 0 and 1. `ad_o` carries address bits 7:0 with `ad_oe`=1 in phases 0 to 2. `bus_ahi` carries address bits 15:8 with `ahi_oe`=1 for the whole access.
- R4: On a read (`req_write`=0), `rd_n` is low in phases 3 to 6 and `ad_oe` is 0 from phase 3 onward. `rsp_rdata` returns the value of `bus_ad_i` sampled at the edge that ends phase 6.
- R5: On a write (`req_write`=1), `wr_n` is low in phases 3 to 6. `ad_o` carries the write data with `ad_oe`=1 in phases 3 to 7, so the data stays driven one tick after `wr_n` rises.
- R6: `wait_n` is sampled at the edge that ends phase 5. Each low sample holds the access in phase 5, with the strobe still low, for 8 more ticks. After those 8 ticks `wait_n` is sampled again.
- R7: An address is internal, and gets no pin activity, if it lies in FFC0h to FFF7h, or if `rom_internal`=1 and it lies in 0000h to 3FFFh. For an internal address, `rsp_done`=1, `rsp_ext`=0 and `rsp_rdata`=0 in the tick after acceptance.
- R8: An external access gives one `rsp_done` pulse in phase 7 with `rsp_ext`=1. `rsp_rdata` is 0 for a write. `rsp_done` is never high for two ticks in a row.
- R9: Outside an external access, `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0 and `ahi_oe`=0. After a read, the next `ale` rises no sooner than 2 ticks after `rd_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the oscillator rate |
| rst_n | input | 1 | Active-low synchronous reset |
| rom_internal | input | 1 | 1 when on-chip ROM serves the low 16 KB |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this tick if valid |
| req_addr | input | 16 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-tick completion pulse |
| rsp_ext | output | 1 | With rsp_done: 1 if the access went to the pins |
| rsp_rdata | output | 8 | With rsp_done: read data |
| ad_o | output | 8 | Shared address/data bus, outgoing value |
| ad_oe | output | 1 | Shared bus output enable |
| bus_ad_i | input | 8 | Shared bus, incoming value |
| bus_ahi | output | 8 | Upper address byte |
| ahi_oe | output | 1 | Upper address output enable |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| clk_out | output | 1 | Clock output, block clock divided by 8 |
| wait_n | input | 1 | Active-low stretch request from the device |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit data byte and a 3-bit clock divider. The ROM window ends at 4000h and the I/O window spans FFC0h to FFF7h. With these values the bench can place addresses on both sides of every decode edge (3FFFh/4000h, FFBFh/FFC0h, FFF7h/FFF8h) with `rom_internal` at both values. The 3-bit divider keeps each stretch at 8 ticks, so reads and writes with zero to two stretches finish quickly. The exact phase-by-phase strobe and bus pattern can then be checked on every access.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
  localparam int PH_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUS   = 2'd1,
    ST_IDONE = 2'd2
  } xmb_state_e;

  // Phase indices of one external access (one tick = half oscillator period)
  localparam logic [PH_W-1:0] PH_ALE_END   = 3'd1;
  localparam logic [PH_W-1:0] PH_ADDR_END  = 3'd2;
  localparam logic [PH_W-1:0] PH_STB_FIRST = 3'd3;
  localparam logic [PH_W-1:0] PH_WAIT      = 3'd5;
  localparam logic [PH_W-1:0] PH_CAPTURE   = 3'd6;
  localparam logic [PH_W-1:0] PH_LAST      = 3'd7;
endpackage

// File: rtl/xmb_clkdiv.sv
module xmb_clkdiv #(
  parameter int DIV_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic clk_out,
  output logic div_last
);
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  // High in the first half of each period
  assign clk_out  = ~div_q[DIV_W-1];
  assign div_last = &div_q;
endmodule

// File: rtl/xmb_decode.sv
module xmb_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] ROM_END = 16'h4000,
  parameter logic [ADDR_W-1:0] IO_LO   = 16'hFFC0,
  parameter logic [ADDR_W-1:0] IO_HI   = 16'hFFF7
) (
  input  logic              rom_internal,
  input  logic [ADDR_W-1:0] addr,
  output logic              int_hit
);
  logic rom_hit, io_hit;

  assign rom_hit = rom_internal && (addr < ROM_END);
  assign io_hit  = (addr >= IO_LO) && (addr <= IO_HI);
  assign int_hit = rom_hit || io_hit;
endmodule

// File: rtl/xmb_seq.sv
module xmb_seq
  import xmb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cyc_start,
  input  logic                     int_start,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     write,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     wait_n,
  input  logic [DATA_W-1:0]        bus_ad_i,
  output logic                     idle,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] bus_ahi,
  output logic                     ahi_oe,
  output logic                     done,
  output logic                     ext,
  output logic [DATA_W-1:0]        rdata
);
  localparam logic [DIV_W-1:0] STRETCH_RELOAD = {DIV_W{1'b1}};

  xmb_state_e        state;
  logic [PH_W-1:0]   ph;
  logic [DIV_W-1:0]  wcnt;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ph      <= '0;
      wcnt    <= '0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cyc_start) begin
            state   <= ST_BUS;
            ph      <= '0;
            wcnt    <= '0;
            addr_q  <= addr;
            wr_q    <= write;
            wdata_q <= wdata;
            rdata_q <= '0;
          end else if (int_start) begin
            state   <= ST_IDONE;
            rdata_q <= '0;
          end
        end
        ST_BUS: begin
          if (ph == PH_CAPTURE && !wr_q) rdata_q <= bus_ad_i;
          if (ph == PH_WAIT && wcnt != '0)      wcnt  <= wcnt - 1'b1;
          else if (ph == PH_WAIT && !wait_n)    wcnt  <= STRETCH_RELOAD;
          else if (ph == PH_LAST)               state <= ST_IDLE;
          else                                  ph    <= ph + 1'b1;
        end
        ST_IDONE: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  logic busy, addr_phase, strobe;
  assign busy       = (state == ST_BUS);
  assign addr_phase = busy && (ph <= PH_ADDR_END);
  assign strobe     = busy && (ph >= PH_STB_FIRST) && (ph < PH_LAST);

  assign idle    = (state == ST_IDLE);
  assign ale     = busy && (ph <= PH_ALE_END);
  assign rd_n    = ~(strobe && !wr_q);
  assign wr_n    = ~(strobe && wr_q);
  assign ad_oe   = addr_phase || (busy && wr_q);
  assign ad_o    = addr_phase ? addr_q[DATA_W-1:0] : wdata_q;
  assign ahi_oe  = busy;
  assign bus_ahi = addr_q[ADDR_W-1:DATA_W];
  assign ext     = busy && (ph == PH_LAST);
  assign done    = ext || (state == ST_IDONE);
  assign rdata   = rdata_q;
endmodule

// File: rtl/xmem_mux_bus.sv
module xmem_mux_bus #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 3,
  parameter logic [ADDR_W-1:0] ROM_END = 16'h4000,
  parameter logic [ADDR_W-1:0] IO_LO   = 16'hFFC0,
  parameter logic [ADDR_W-1:0] IO_HI   = 16'hFFF7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rom_internal,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_done,
  output logic                     rsp_ext,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        bus_ad_i,
  output logic [ADDR_W-DATA_W-1:0] bus_ahi,
  output logic                     ahi_oe,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     clk_out,
  input  logic                     wait_n
);
  logic div_last, int_hit, seq_idle, accept;

  xmb_clkdiv #(.DIV_W(DIV_W)) clkdiv_i (
    .clk(clk), .rst_n(rst_n), .clk_out(clk_out), .div_last(div_last)
  );

  xmb_decode #(.ADDR_W(ADDR_W), .ROM_END(ROM_END), .IO_LO(IO_LO), .IO_HI(IO_HI)) decode_i (
    .rom_internal(rom_internal), .addr(req_addr), .int_hit(int_hit)
  );

  assign req_ready = seq_idle && div_last;
  assign accept    = req_valid && req_ready;

  xmb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .cyc_start(accept && !int_hit), .int_start(accept && int_hit),
    .addr(req_addr), .write(req_write), .wdata(req_wdata),
    .wait_n(wait_n), .bus_ad_i(bus_ad_i),
    .idle(seq_idle), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .ad_o(ad_o), .ad_oe(ad_oe), .bus_ahi(bus_ahi), .ahi_oe(ahi_oe),
    .done(rsp_done), .ext(rsp_ext), .rdata(rsp_rdata)
  );
endmodule

// File: rtl/xmb_checker.sv
module xmb_checker #(
  parameter int HI_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ale,
  input logic            rd_n,
  input logic            wr_n,
  input logic            ad_oe,
  input logic            ahi_oe,
  input logic [HI_W-1:0] bus_ahi,
  input logic            rsp_done,
  input logic            req_ready,
  input logic            clk_out
);
  // R2: acceptance only in the low half of the clock output
  a_r2_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !clk_out);

  // R3: latch strobe is exactly two ticks wide
  a_r3_ale_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> (ale ##1 !ale));

  // R3: low address still driven, no strobe, right after the latch strobe falls
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (ad_oe && rd_n && wr_n));

  // R3: upper address steady through an access
  a_r3_upper_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ahi_oe && $past(ahi_oe)) |-> $stable(bus_ahi));

  // R4: bus released while reading
  a_r4_read_float: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R4: read and write strobes never together
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (rd_n || wr_n));

  // R5: data driven whenever the write strobe is low
  a_r5_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  // R8: completion is a single-tick pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R9: pins quiet outside an access
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ahi_oe |-> (rd_n && wr_n && !ale && !ad_oe));
endmodule

bind xmem_mux_bus xmb_checker #(.HI_W(ADDR_W-DATA_W)) chk_i (.*);

// File: tb/xmem_mux_bus_tb_top.sv
`timescale 1ns/1ps
module xmem_mux_bus_tb_top;
  logic clk = 1'b0;
  logic rst_n, rom_internal, req_valid, req_write, wait_n;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata, bus_ad_i;
  logic req_ready, rsp_done, rsp_ext, ad_oe, ahi_oe, ale, rd_n, wr_n, clk_out;
  logic [7:0] rsp_rdata, ad_o, bus_ahi;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  xmem_mux_bus dut_i (
    .clk(clk), .rst_n(rst_n), .rom_internal(rom_internal),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_ext(rsp_ext), .rsp_rdata(rsp_rdata),
    .ad_o(ad_o), .ad_oe(ad_oe), .bus_ad_i(bus_ad_i),
    .bus_ahi(bus_ahi), .ahi_oe(ahi_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .clk_out(clk_out), .wait_n(wait_n)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  function automatic bit is_internal(input logic [15:0] a, input bit rom);
    return (rom && a <= 16'h3FFF) || (a >= 16'hFFC0 && a <= 16'hFFF7);
  endfunction

  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
    chk("R2 clk_out low at ready", 32'(clk_out), 32'd0);
  endtask

  task automatic check_quiet(input string tag);
    chk({tag, " ale"},    32'(ale),    32'd0);
    chk({tag, " rd_n"},   32'(rd_n),   32'd1);
    chk({tag, " wr_n"},   32'(wr_n),   32'd1);
    chk({tag, " ad_oe"},  32'(ad_oe),  32'd0);
    chk({tag, " ahi_oe"}, 32'(ahi_oe), 32'd0);
  endtask

  task automatic run_ext(input logic [15:0] a, input bit w, input logic [7:0] d,
                         input int nw, input logic [7:0] rv);
    int total;
    wait_ready();
    req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_write = ~w;
    total = 8 + 8 * nw;
    for (int t = 0; t < total; t++) begin
      int ph;
      bit e_oe, e_done;
      string tag;
      ph = (t <= 5) ? t : ((t < 5 + 8 * nw) ? 5 : t - 8 * nw);
      tag = (t > 5 && ph == 5) ? "R6" : (w ? "R5" : "R4");
      chk("R2 clk_out", 32'(clk_out), 32'((t % 8) < 4));
      chk("R3 ale", 32'(ale), 32'(ph <= 1));
      chk("R3 ahi_oe", 32'(ahi_oe), 32'd1);
      chk("R3 bus_ahi", 32'(bus_ahi), 32'(a[15:8]));
      chk({tag, " rd_n"}, 32'(rd_n), 32'(!(!w && ph >= 3 && ph <= 6)));
      chk({tag, " wr_n"}, 32'(wr_n), 32'(!(w && ph >= 3 && ph <= 6)));
      e_oe = (ph <= 2) || w;
      chk({tag, " ad_oe"}, 32'(ad_oe), 32'(e_oe));
      if (ph <= 2)  chk("R3 ad_o addr", 32'(ad_o), 32'(a[7:0]));
      else if (w)   chk("R5 ad_o data", 32'(ad_o), 32'(d));
      e_done = (t == total - 1);
      chk("R8 rsp_done", 32'(rsp_done), 32'(e_done));
      if (e_done) begin
        chk("R8 rsp_ext", 32'(rsp_ext), 32'd1);
        chk(w ? "R8 rdata on write" : "R4 rdata", 32'(rsp_rdata), 32'(w ? 8'h00 : rv));
      end
      wait_n   = !((t >= 5) && ((t - 5) % 8 == 0) && ((t - 5) / 8 < nw));
      bus_ad_i = (ph == 6) ? rv : ~rv;
      @(negedge clk);
    end
    wait_n = 1'b1;
    chk("R8 done cleared", 32'(rsp_done), 32'd0);
    check_quiet("R9 after access");
    if (!w) begin
      // RD rose two ticks ago at most; next ale cannot be up yet
      @(negedge clk);
      chk("R9 turnaround ale", 32'(ale), 32'd0);
    end
  endtask

  task automatic run_int(input logic [15:0] a);
    wait_ready();
    req_valid = 1'b1; req_addr = a; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 done", 32'(rsp_done), 32'd1);
    chk("R7 ext", 32'(rsp_ext), 32'd0);
    chk("R7 rdata", 32'(rsp_rdata), 32'd0);
    check_quiet("R7 pins");
    @(negedge clk);
    chk("R8 single pulse", 32'(rsp_done), 32'd0);
    check_quiet("R7 pins after");
  endtask

  task automatic run_any(input logic [15:0] a, input bit rom, input bit w,
                         input logic [7:0] d, input int nw, input logic [7:0] rv);
    rom_internal = rom;
    if (is_internal(a, rom)) run_int(a);
    else                     run_ext(a, w, d, nw, rv);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [15:0] edges [6];
    int unsigned seed_v;
    seed_v = $urandom(32'h5EED);
    edges[0] = 16'h3FFF; edges[1] = 16'h4000; edges[2] = 16'hFFBF;
    edges[3] = 16'hFFC0; edges[4] = 16'hFFF7; edges[5] = 16'hFFF8;
    rst_n = 1'b0; rom_internal = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; wait_n = 1'b1; bus_ad_i = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_quiet("R1 reset");
    chk("R1 reset done", 32'(rsp_done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 clk_out first tick", 32'(clk_out), 32'd1);
    check_quiet("R9 idle");

    // directed
    run_any(16'h1234, 1'b0, 1'b0, 8'h00, 0, 8'hA5);
    run_any(16'h8001, 1'b0, 1'b1, 8'h3C, 0, 8'h00);
    run_any(16'h5A5A, 1'b1, 1'b0, 8'h00, 2, 8'h96);
    run_any(16'hC0DE, 1'b1, 1'b1, 8'hE7, 1, 8'h00);
    run_any(16'h3FFF, 1'b1, 1'b0, 8'h00, 0, 8'h11);
    run_any(16'h3FFF, 1'b0, 1'b0, 8'h00, 0, 8'h22);
    run_any(16'h4000, 1'b1, 1'b1, 8'h44, 0, 8'h00);
    run_any(16'hFFBF, 1'b0, 1'b0, 8'h00, 1, 8'h5B);
    run_any(16'hFFC0, 1'b0, 1'b1, 8'h66, 0, 8'h00);
    run_any(16'hFFF7, 1'b1, 1'b0, 8'h00, 0, 8'h77);
    run_any(16'hFFF8, 1'b0, 1'b0, 8'h00, 0, 8'h88);
    run_any(16'h0000, 1'b1, 1'b1, 8'h99, 0, 8'h00);

    // constrained random
    for (int i = 0; i < 80; i++) begin
      logic [15:0] a;
      a = ($urandom % 2 == 0) ? edges[$urandom % 6] : 16'($urandom);
      run_any(a, 1'($urandom), 1'($urandom), 8'($urandom), int'($urandom % 3), 8'($urandom));
    end
    finish_up();
  end
endmodule